// File: doc/BRIEF.md
# Peripheral Bus Clock Gating Controller

This block sits between a simple register bus and a group of peripherals. It keeps one software-writable clock-enable bit per peripheral. The bits are spread over three 8-bit control registers. For each peripheral it drives two outputs: a registered clock enable and a glitch-free gated bus clock. The gated clock comes from a cell that samples the enable only while the clock is low.

The block decodes every bus access. An address either hits the control registers, hits the window of one peripheral, or hits nothing. Peripheral windows follow each other from a base address, and each has a fixed span. The block passes a write or read strobe on to a peripheral only when that peripheral's clock is on. An access to a gated peripheral is dropped: a read returns zero, and an "access void" flag marks the access as having had no effect. Reads of the control registers always return the current enable bits, whatever state the gated clocks are in.

Top module: `periph_clk_gate_ctrl`

## Requirements
- R1: After reset every implemented enable bit takes its bit from parameter EN_RESET (default all ones). per_clk_en shows these bits, and so do the readbacks of the control registers.
- R2: Control register k (k = 0, 1, 2) sits at address CTRL_BASE+k and holds the enable of peripheral 8k+b in bit b. A write stores bus_wdata into the implemented bits. Bits for peripherals at or above NUM_PERIPH ignore writes and read as zero.
- R3: A control-register write is sampled on a rising clock edge, and per_clk_en changes on that same edge. No other access changes per_clk_en.
- R4: After that edge, per_clk[i] pulses on every rising clock edge while the enable is 1. It stays low while the enable is 0. It changes level only while the clock is low, so no runt pulse appears.
- R5: Peripheral i owns addresses PERIPH_BASE+i*PERIPH_SPAN up to, but not including, PERIPH_BASE+(i+1)*PERIPH_SPAN. per_we[i] is bus_we for an address in that window, and only while enable i is 1.
- R6: per_re[i] follows the same rule with bus_re.
- R7: A read of an enabled peripheral's window returns per_rdata[8i+7:8i] on bus_rdata in the same cycle. A read of a gated peripheral's window returns zero.
- R8: bus_void is 1 in the cycle of any read or write to a gated peripheral's window, and 0 in every other cycle.
- R9: Reads of the control registers return the enable bits whatever the gating state. An address that hits no window gives no strobes, read data of zero and no bus_void.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data (combinational) |
| bus_void | output | 1 | Access hit a gated peripheral |
| per_rdata | input | 8*NUM_PERIPH | Read data from each peripheral |
| per_we | output | NUM_PERIPH | Filtered write strobe per peripheral |
| per_re | output | NUM_PERIPH | Filtered read strobe per peripheral |
| per_clk_en | output | NUM_PERIPH | Registered clock enable per peripheral |
| per_clk | output | NUM_PERIPH | Gated bus clock per peripheral |

## Verification
A wrong enable bit shows up in several places. It appears on per_clk_en at the edge after the control write. It appears on the control-register readback in the next read, and on the pulse count of the gated clock in the following cycle. A wrong decode or a wrong filter shows up in the same cycle as the access: a strobe or bus_void that is present but should not be, or missing when it should be, or a read value that is not zero. Random accesses mix control writes with peripheral reads and writes. Each outcome is compared, in the cycle it occurs, with a model the bench keeps of the enable bits.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    localparam int unsigned REG_W      = 8;
    localparam int unsigned CTRL_REGS  = 3;
    localparam int unsigned MAX_PERIPH = REG_W * CTRL_REGS;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_CTRL   = 2'd1,
        TGT_PERIPH = 2'd2
    } tgt_e;
endpackage

// File: rtl/pcg_addr_decode.sv
module pcg_addr_decode
    import pcg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned NUM_PERIPH  = 12,
    parameter int unsigned CTRL_BASE   = 0,
    parameter int unsigned PERIPH_BASE = 256,
    parameter int unsigned PERIPH_SPAN = 16
) (
    input  logic [ADDR_W-1:0]     addr,
    output tgt_e                  tgt,
    output logic [1:0]            ctrl_idx,
    output logic [NUM_PERIPH-1:0] hit
);
    localparam int unsigned AW1 = ADDR_W + 1;

    logic [AW1-1:0] addr_x;
    logic           ctrl_hit;

    assign addr_x = {1'b0, addr};

    // Control register window: CTRL_REGS consecutive addresses
    assign ctrl_hit = (addr_x >= AW1'(CTRL_BASE)) &&
                      (addr_x <  AW1'(CTRL_BASE + CTRL_REGS));

    always_comb begin
        ctrl_idx = 2'd0;
        if (ctrl_hit) begin
            ctrl_idx = 2'(addr_x - AW1'(CTRL_BASE));
        end
    end

    // One range comparator per peripheral window
    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_win
        localparam int unsigned LO = PERIPH_BASE + g * PERIPH_SPAN;
        localparam int unsigned HI = LO + PERIPH_SPAN;
        assign hit[g] = (addr_x >= AW1'(LO)) && (addr_x < AW1'(HI));
    end

    always_comb begin
        if (ctrl_hit) begin
            tgt = TGT_CTRL;
        end else if (|hit) begin
            tgt = TGT_PERIPH;
        end else begin
            tgt = TGT_NONE;
        end
    end
endmodule

// File: rtl/pcg_enable_bank.sv
module pcg_enable_bank
    import pcg_pkg::*;
#(
    parameter int unsigned       NUM_PERIPH = 12,
    parameter logic [MAX_PERIPH-1:0] EN_RESET = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_idx,
    input  logic [REG_W-1:0]      wr_data,
    input  logic [1:0]            rd_idx,
    output logic [REG_W-1:0]      rd_data,
    output logic [NUM_PERIPH-1:0] en
);
    localparam logic [NUM_PERIPH-1:0] EN_INIT = EN_RESET[NUM_PERIPH-1:0];

    typedef struct packed {
        logic [NUM_PERIPH-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_PERIPH; i++) begin
                if (2'(i / REG_W) == wr_idx) begin
                    st_d.en[i] = wr_data[i % REG_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en <= EN_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    // Readback: bits beyond NUM_PERIPH stay zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_PERIPH; i++) begin
            if (2'(i / REG_W) == rd_idx) begin
                rd_data[i % REG_W] = st_q.en[i];
            end
        end
    end

    assign en = st_q.en;
endmodule

// File: rtl/pcg_clk_gate.sv
module pcg_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // Transparent while clk is low; holds through the high phase
    always_latch begin
        if (!clk) begin
            en_lat = en;
        end
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/periph_clk_gate_ctrl.sv
module periph_clk_gate_ctrl
    import pcg_pkg::*;
#(
    parameter int unsigned           ADDR_W      = 12,
    parameter int unsigned           NUM_PERIPH  = 12,
    parameter int unsigned           CTRL_BASE   = 0,
    parameter int unsigned           PERIPH_BASE = 256,
    parameter int unsigned           PERIPH_SPAN = 16,
    parameter logic [MAX_PERIPH-1:0] EN_RESET    = '1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [REG_W-1:0]              bus_wdata,
    input  logic                          bus_we,
    input  logic                          bus_re,
    output logic [REG_W-1:0]              bus_rdata,
    output logic                          bus_void,
    input  logic [REG_W*NUM_PERIPH-1:0]   per_rdata,
    output logic [NUM_PERIPH-1:0]         per_we,
    output logic [NUM_PERIPH-1:0]         per_re,
    output logic [NUM_PERIPH-1:0]         per_clk_en,
    output logic [NUM_PERIPH-1:0]         per_clk
);
    tgt_e                  tgt;
    logic [1:0]            ctrl_idx;
    logic [NUM_PERIPH-1:0] hit;
    logic [NUM_PERIPH-1:0] live_hit;
    logic [REG_W-1:0]      ctrl_rdata;
    logic [REG_W-1:0]      per_sel;
    logic                  ctrl_wr;

    pcg_addr_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_PERIPH  (NUM_PERIPH),
        .CTRL_BASE   (CTRL_BASE),
        .PERIPH_BASE (PERIPH_BASE),
        .PERIPH_SPAN (PERIPH_SPAN)
    ) i_dec (
        .addr     (bus_addr),
        .tgt      (tgt),
        .ctrl_idx (ctrl_idx),
        .hit      (hit)
    );

    assign ctrl_wr = bus_we && (tgt == TGT_CTRL);

    pcg_enable_bank #(
        .NUM_PERIPH (NUM_PERIPH),
        .EN_RESET   (EN_RESET)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wr_idx  (ctrl_idx),
        .wr_data (bus_wdata),
        .rd_idx  (ctrl_idx),
        .rd_data (ctrl_rdata),
        .en      (per_clk_en)
    );

    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_gate
        pcg_clk_gate i_cg (
            .clk  (clk),
            .en   (per_clk_en[g]),
            .gclk (per_clk[g])
        );
    end

    // Strobe filter: only a clocked peripheral sees its strobes
    assign live_hit = hit & per_clk_en;
    assign per_we   = live_hit & {NUM_PERIPH{bus_we}};
    assign per_re   = live_hit & {NUM_PERIPH{bus_re}};
    assign bus_void = (bus_we | bus_re) && (tgt == TGT_PERIPH) && ((hit & ~per_clk_en) != '0);

    always_comb begin
        per_sel = '0;
        for (int i = 0; i < NUM_PERIPH; i++) begin
            if (live_hit[i]) begin
                per_sel = per_rdata[i*REG_W +: REG_W];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (tgt)
                TGT_CTRL:   bus_rdata = ctrl_rdata;
                TGT_PERIPH: bus_rdata = per_sel;
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker
    import pcg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned NUM_PERIPH = 12,
    parameter int unsigned CTRL_BASE  = 0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [REG_W-1:0]      bus_wdata,
    input logic                  bus_we,
    input logic                  bus_re,
    input logic [REG_W-1:0]      bus_rdata,
    input logic                  bus_void,
    input logic [NUM_PERIPH-1:0] per_we,
    input logic [NUM_PERIPH-1:0] per_re,
    input logic [NUM_PERIPH-1:0] per_clk_en
);
    localparam int unsigned L0  = (NUM_PERIPH < REG_W) ? NUM_PERIPH : REG_W;
    localparam int unsigned AW1 = ADDR_W + 1;

    logic ctrl_acc;
    assign ctrl_acc = ({1'b0, bus_addr} >= AW1'(CTRL_BASE)) &&
                      ({1'b0, bus_addr} <  AW1'(CTRL_BASE + CTRL_REGS));

    // R5
    we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_we & ~per_clk_en) == '0);

    // R5
    we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(per_we));

    // R6
    re_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_re & ~per_clk_en) == '0);

    // R7
    void_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_void) |-> (bus_rdata == '0));

    // R8
    void_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && !bus_re) |-> !bus_void);

    // R3
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && ctrl_acc) |=> $stable(per_clk_en));

    // R3
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == ADDR_W'(CTRL_BASE))) |=>
        (per_clk_en[L0-1:0] == $past(bus_wdata[L0-1:0])));
endmodule

bind periph_clk_gate_ctrl pcg_checker #(
    .ADDR_W     (ADDR_W),
    .NUM_PERIPH (NUM_PERIPH),
    .CTRL_BASE  (CTRL_BASE)
) i_pcg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .bus_void   (bus_void),
    .per_we     (per_we),
    .per_re     (per_re),
    .per_clk_en (per_clk_en)
);

// File: tb/test_periph_clk_gate_ctrl.sv
module test_periph_clk_gate_ctrl;
    localparam int AW    = 12;
    localparam int NP    = 12;
    localparam int CBASE = 0;
    localparam int PBASE = 256;
    localparam int SPAN  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [7:0]      bus_wdata = '0;
    logic            bus_we = 1'b0;
    logic            bus_re = 1'b0;
    logic [7:0]      bus_rdata;
    logic            bus_void;
    logic [8*NP-1:0] per_rdata = '0;
    logic [NP-1:0]   per_we, per_re, per_clk_en, per_clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [NP-1:0] model_en;
    int unsigned gcnt [NP];

    always #10 clk = ~clk;

    periph_clk_gate_ctrl #(
        .ADDR_W(AW), .NUM_PERIPH(NP), .CTRL_BASE(CBASE),
        .PERIPH_BASE(PBASE), .PERIPH_SPAN(SPAN)
    ) i_periph_clk_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_void(bus_void),
        .per_rdata(per_rdata), .per_we(per_we), .per_re(per_re),
        .per_clk_en(per_clk_en), .per_clk(per_clk)
    );

    for (genvar g = 0; g < NP; g++) begin : g_cnt
        initial gcnt[g] = 0;
        always @(posedge per_clk[g]) gcnt[g] = gcnt[g] + 1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // -1 none, 100..102 control register, 0..NP-1 peripheral
    function automatic int target(input logic [AW-1:0] a);
        int ai = int'(a);
        if (ai >= CBASE && ai < CBASE + 3) return 100 + (ai - CBASE);
        if (ai >= PBASE && ai < PBASE + NP * SPAN) return (ai - PBASE) / SPAN;
        return -1;
    endfunction

    function automatic logic [7:0] reg_view(input int k);
        logic [7:0] r = '0;
        for (int b = 0; b < 8; b++) if (8 * k + b < NP) r[b] = model_en[8 * k + b];
        return r;
    endfunction

    task automatic bus_op(input bit wr, input bit rd, input logic [AW-1:0] a, input logic [7:0] d);
        int t = target(a);
        logic [NP-1:0] exp_we = '0;
        logic [NP-1:0] exp_re = '0;
        logic [7:0] exp_rd = '0;
        bit exp_void = 0;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = wr; bus_re = rd;
        for (int i = 0; i < NP; i++) per_rdata[8*i +: 8] = 8'($urandom);
        #2;
        if (t >= 0 && t < NP) begin
            if (model_en[t]) begin
                exp_we[t] = wr; exp_re[t] = rd;
                if (rd) exp_rd = per_rdata[8*t +: 8];
            end else begin
                exp_void = wr | rd;
            end
        end else if (t >= 100 && rd) begin
            exp_rd = reg_view(t - 100);
        end
        check(per_we == exp_we, "R5 per_we", per_we, exp_we);
        check(per_re == exp_re, "R6 per_re", per_re, exp_re);
        check(bus_void == exp_void, "R8 bus_void", bus_void, exp_void);
        if (rd) check(bus_rdata == exp_rd, (t >= 100) ? "R9 ctrl readback" :
                      (t < 0) ? "R9 unmapped read" : "R7 read data", bus_rdata, exp_rd);
        check(per_clk_en == model_en, "R3 enable held before edge", per_clk_en, model_en);
        @(posedge clk);
        #1;
        if (wr && t >= 100) begin
            for (int b = 0; b < 8; b++)
                if (8 * (t - 100) + b < NP) model_en[8 * (t - 100) + b] = d[b];
        end
        check(per_clk_en == model_en, "R3 enable after edge", per_clk_en, model_en);
        bus_we = 0; bus_re = 0;
    endtask

    task automatic clk_window;
        int unsigned snap [NP];
        @(negedge clk);
        for (int i = 0; i < NP; i++) snap[i] = gcnt[i];
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            int unsigned e = model_en[i] ? 3 : 0;
            check(gcnt[i] - snap[i] == e, "R4 gated clock pulses", gcnt[i] - snap[i], e);
        end
        for (int i = 0; i < NP; i++)
            check(per_clk[i] == 1'b0, "R4 gated clock low in low phase", per_clk[i], 0);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C61));
        model_en = '1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        check(per_clk_en == {NP{1'b1}}, "R1 reset enables", per_clk_en, {NP{1'b1}});
        bus_op(0, 1, AW'(CBASE + 0), 8'h00);
        bus_op(0, 1, AW'(CBASE + 1), 8'h00);
        bus_op(0, 1, AW'(CBASE + 2), 8'h00);
        clk_window();
        // R2 unused bits ignore writes and read zero
        bus_op(1, 0, AW'(CBASE + 1), 8'hA5);
        bus_op(0, 1, AW'(CBASE + 1), 8'h00);
        check(bus_rdata == 8'h05, "R2 upper bits read zero", bus_rdata, 8'h05);
        bus_op(1, 0, AW'(CBASE + 2), 8'hFF);
        bus_op(0, 1, AW'(CBASE + 2), 8'h00);
        clk_window();
        // R9 all gated, readback still valid; gated peripherals drop access
        bus_op(1, 0, AW'(CBASE + 0), 8'h00);
        bus_op(1, 0, AW'(CBASE + 1), 8'h00);
        bus_op(0, 1, AW'(CBASE + 0), 8'h00);
        bus_op(1, 0, AW'(PBASE), 8'h3C);
        bus_op(0, 1, AW'(PBASE + NP * SPAN - 1), 8'h00);
        clk_window();
        // R5 window edges
        bus_op(1, 0, AW'(CBASE + 0), 8'h01);
        bus_op(1, 0, AW'(PBASE + SPAN - 1), 8'h11);
        bus_op(1, 0, AW'(PBASE + SPAN), 8'h22);
        bus_op(0, 1, AW'(PBASE - 1), 8'h00);
        bus_op(0, 1, AW'(PBASE + NP * SPAN), 8'h00);
        clk_window();
        // Random mix
        for (int n = 0; n < 400; n++) begin
            int kind = int'($urandom_range(0, 9));
            logic [AW-1:0] a;
            if (kind < 3) a = AW'(CBASE + int'($urandom_range(0, 2)));
            else if (kind < 9) a = AW'(PBASE + int'($urandom_range(0, NP * SPAN - 1)));
            else a = AW'($urandom);
            if (kind < 3) bus_op(1, 0, a, 8'($urandom));
            else bus_op(($urandom & 1) == 1, ($urandom & 2) == 2, a, 8'($urandom));
            if (n % 50 == 0) clk_window();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule